// File: doc/BRIEF.md
# Telephone line switch control sequencer

This block is the digital control core of a two-pole line-card access switch. It turns a three-bit mode word into on/off enables for four switch groups: the break pair, the ringing return switch, the ringing switch and the test pair. A latch enable can freeze the mode word. Several override conditions force every switch open: an active-low off input, an external active-low thermal input, an internal over-temperature flag, supply loss, a battery window with hysteresis, and a start-up lock.

The ringing switch has one special rule. Once it is closed, it opens only on a ringing-current zero crossing. A command to open it stays pending until the zero-crossing strobe arrives. Mode changes straight from ringing to talk therefore give a make-before-break transient. Opening everything first with the off input gives break-before-make.

All pins are plain level controls with no data stream, so there is no handshake and no back-pressure. The zero-crossing strobe is the only asynchronous input, and it is resynchronized inside the block. All other inputs are taken as synchronous to `clk`.

Top module: `lcas_ctrl_top`

## Requirements
- R1: During and right after reset, all four switch enables are 0 and `therm_flag_n_o` is 1.
- R2: While `hold_i` is 0, a mode word sampled at clock edge k sets the switch enables at edge k+1.
- R3: While `hold_i` is 1, the mode word captured at the last edge where `hold_i` was 0 stays in force, and changes on `mode_i` have no effect on the enables.
- R4: Decoding uses `mode_i` bit0=P1, bit1=P2, bit2=P3. Code 000 (talk) closes only the break pair. Code 010 (ringing) closes the ringing return and ringing switches. Every other code opens all switches. The test enable is never set.
- R5: When `kill_n_i` or `therm_n_i` is 0 at edge k, the break, return and test enables are 0 from edge k, whatever is latched.
- R6: Once `ring_en_o` is 1, it stays 1 until a zero crossing. A rising edge on `zc_i` sampled at edge k opens a pending ringing switch at edge k+2. A zero crossing while ringing is still commanded has no effect.
- R7: A direct change from ringing to talk gives break=1, return=0, ring=1 until the zero crossing. After that it gives break=1, ring=0.
- R8: Driving `kill_n_i` low while ringing opens the return switch at once and keeps the ring switch closed until a zero crossing. Releasing `kill_n_i` with talk latched closes the break pair on the next edge.
- R9: While `pwr_good_i` is 0, all enables go to 0 at the next edge. After power returns, the enables stay 0 until `hold_i` has been sampled 0. They follow the mode one edge after that sample.
- R10: `bat_fail_i` at edge k blocks all enables from edge k+1. The block lasts until an edge where `bat_ok_i` is 1 and `bat_fail_i` is 0. Enables return one edge after that.
- R11: `therm_int_i` at edge k forces all-off and drives `therm_flag_n_o` low from edge k. With `therm_n_i` held at 1, that input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Mode word (bit0 P1, bit1 P2, bit2 P3) |
| hold_i | input | 1 | 1 freezes the mode word, 0 passes it through |
| kill_n_i | input | 1 | Active-low force all-off, not gated by the hold |
| therm_n_i | input | 1 | External active-low thermal shutdown request |
| therm_int_i | input | 1 | Internal over-temperature flag, active high |
| therm_flag_n_o | output | 1 | Thermal shutdown status, low while over-temperature |
| pwr_good_i | input | 1 | Supply-good flag |
| bat_fail_i | input | 1 | Battery lost or too positive |
| bat_ok_i | input | 1 | Battery back past the lower recovery threshold |
| zc_i | input | 1 | Asynchronous ringing-current zero-crossing strobe |
| brk_en_o | output | 1 | Break pair enable |
| rret_en_o | output | 1 | Ringing return switch enable |
| ring_en_o | output | 1 | Ringing switch enable |
| test_en_o | output | 1 | Test pair enable |

## Verification
The mode word is driven through talk, ringing and each of the six undefined codes. Together these separate the correct decode from crossed or missing switch groups. Ringing-to-talk transitions are made both directly and through the off input, so that a ring switch that drops too early or opens without a zero crossing shows up. Zero crossings are also sent while ringing is still commanded, to catch a release that ignores the command. Hold, supply, battery and thermal sequences each check their override against the latched mode, including the arming and hysteresis steps that only a return from fault exposes.

// File: rtl/lcas_pkg.sv
package lcas_pkg;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic brk;
    logic rret;
    logic ring;
    logic test;
  } sw_set_t;

  typedef enum logic [MODE_W-1:0] {
    MODE_TALK = 3'b000,
    MODE_RING = 3'b010
  } mode_e;

  localparam sw_set_t SW_ALL_OFF = '0;

  function automatic sw_set_t decode_mode(input logic [MODE_W-1:0] m);
    sw_set_t s;
    s = SW_ALL_OFF;
    case (m)
      MODE_TALK: s.brk = 1'b1;
      MODE_RING: begin
        s.rret = 1'b1;
        s.ring = 1'b1;
      end
      default: s = SW_ALL_OFF;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lcas_zc_sync.sv
module lcas_zc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_i,
  output logic zc_pulse_o
);
  localparam int LAST = STAGES;
  logic [LAST:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= zc_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign zc_pulse_o = chain_q[LAST-1] & ~chain_q[LAST];

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zc_pulse_o |=> !zc_pulse_o);
endmodule

// File: rtl/lcas_in_latch.sv
module lcas_in_latch
  import lcas_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic [MODE_W-1:0] mode_i,
  output sw_set_t           cmd_o
);
  logic [MODE_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       word_q <= '1;
    else if (!hold_i) word_q <= mode_i;

  assign cmd_o = decode_mode(word_q);

  assert_hold_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(word_q));
  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> (word_q == $past(mode_i)));
endmodule

// File: rtl/lcas_guard.sv
module lcas_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  input  logic hold_i,
  input  logic kill_n_i,
  input  logic therm_n_i,
  input  logic therm_int_i,
  input  logic bat_fail_i,
  input  logic bat_ok_i,
  output logic force_o,
  output logic therm_flag_n_o
);
  logic armed_q;
  logic bat_blk_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           armed_q <= 1'b0;
    else if (!pwr_good_i) armed_q <= 1'b0;
    else if (!hold_i)     armed_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          bat_blk_q <= 1'b0;
    else if (bat_fail_i) bat_blk_q <= 1'b1;
    else if (bat_ok_i)   bat_blk_q <= 1'b0;

  assign force_o = !kill_n_i | !therm_n_i | therm_int_i | !pwr_good_i
                 | !armed_q | bat_blk_q;
  assign therm_flag_n_o = !therm_int_i;

  assert_unpowered_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good_i |=> force_o || !armed_q);
  assert_bat_hyst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_blk_q && !bat_ok_i) |=> bat_blk_q);
endmodule

// File: rtl/lcas_sw_drv.sv
module lcas_sw_drv
  import lcas_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sw_set_t cmd_i,
  input  logic    force_i,
  input  logic    zc_pulse_i,
  output logic    brk_o,
  output logic    rret_o,
  output logic    ring_o,
  output logic    test_o
);
  sw_set_t tgt;
  logic    ring_nxt;
  logic    pend_q;

  assign tgt      = force_i ? SW_ALL_OFF : cmd_i;
  assign ring_nxt = tgt.ring | (ring_o & ~zc_pulse_i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      brk_o  <= 1'b0;
      rret_o <= 1'b0;
      ring_o <= 1'b0;
      test_o <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      brk_o  <= tgt.brk;
      rret_o <= tgt.rret;
      test_o <= tgt.test;
      ring_o <= ring_nxt;
      pend_q <= ring_nxt & ~tgt.ring;
    end

  assert_ring_zc_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_o) |-> $past(zc_pulse_i) && $past(pend_q || !cmd_i.ring || force_i));
  assert_ring_close_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_o) |-> $past(cmd_i.ring && !force_i));
  assert_force_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> !brk_o && !rret_o && !test_o);
  assert_brk_rret_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_o && rret_o));
endmodule

// File: rtl/lcas_ctrl_top.sv
module lcas_ctrl_top
  import lcas_pkg::*;
#(
  parameter int ZC_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       hold_i,
  input  logic       kill_n_i,
  input  logic       therm_n_i,
  input  logic       therm_int_i,
  output logic       therm_flag_n_o,
  input  logic       pwr_good_i,
  input  logic       bat_fail_i,
  input  logic       bat_ok_i,
  input  logic       zc_i,
  output logic       brk_en_o,
  output logic       rret_en_o,
  output logic       ring_en_o,
  output logic       test_en_o
);
  sw_set_t cmd;
  logic    force_off;
  logic    zc_pulse;

  lcas_zc_sync #(.STAGES(ZC_SYNC_STAGES)) u_zc (
    .clk(clk), .rst_n(rst_n), .zc_i(zc_i), .zc_pulse_o(zc_pulse)
  );

  lcas_in_latch u_latch (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .mode_i(mode_i), .cmd_o(cmd)
  );

  lcas_guard u_guard (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i), .hold_i(hold_i),
    .kill_n_i(kill_n_i), .therm_n_i(therm_n_i), .therm_int_i(therm_int_i),
    .bat_fail_i(bat_fail_i), .bat_ok_i(bat_ok_i),
    .force_o(force_off), .therm_flag_n_o(therm_flag_n_o)
  );

  lcas_sw_drv u_drv (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .force_i(force_off),
    .zc_pulse_i(zc_pulse), .brk_o(brk_en_o), .rret_o(rret_en_o),
    .ring_o(ring_en_o), .test_o(test_en_o)
  );

  assert_test_never_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en_o);
endmodule

// File: tb/lcas_ctrl_top_tb.sv
module lcas_ctrl_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'b111;
  logic hold = 1'b1, kill_n = 1'b1, therm_n = 1'b1, therm_int = 1'b0;
  logic pg = 1'b0, bat_fail = 1'b0, bat_ok = 1'b0, zc = 1'b0;
  logic tflag_n, brk, rret, ring, test;
  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  lcas_ctrl_top u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .hold_i(hold), .kill_n_i(kill_n),
    .therm_n_i(therm_n), .therm_int_i(therm_int), .therm_flag_n_o(tflag_n),
    .pwr_good_i(pg), .bat_fail_i(bat_fail), .bat_ok_i(bat_ok), .zc_i(zc),
    .brk_en_o(brk), .rret_en_o(rret), .ring_en_o(ring), .test_en_o(test)
  );

  // behavioural reference, updated once per rising edge
  int  m_word;
  bit  m_armed, m_bat, m_brk, m_rret, m_ring;
  bit  zc_hist[$];

  always @(posedge clk) begin
    bit off, want_brk, want_ring, want_rret, zc_edge;
    if (!rst_n) begin
      m_word = 7; m_armed = 0; m_bat = 0;
      m_brk = 0; m_rret = 0; m_ring = 0;
      zc_hist = '{0, 0, 0};
    end else begin
      zc_edge   = zc_hist[1] && !zc_hist[2];
      off       = !kill_n || !therm_n || therm_int || !pg || !m_armed || m_bat;
      want_brk  = !off && (m_word == 0);
      want_ring = !off && (m_word == 2);
      want_rret = want_ring;
      m_brk  = want_brk;
      m_rret = want_rret;
      if (want_ring) m_ring = 1;
      else if (zc_edge) m_ring = 0;
      if (!hold) m_word = int'(mode);
      if (!pg) m_armed = 0;
      else if (!hold) m_armed = 1;
      if (bat_fail) m_bat = 1;
      else if (bat_ok) m_bat = 0;
      zc_hist.push_front(zc);
      void'(zc_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    cyc++;
    tests++;
    if (brk !== m_brk || rret !== m_rret || test !== 1'b0) begin
      fails++;
      $display("FAIL R4 cycle %0d: brk/rret/test=%b%b%b expected %b%b0",
               cyc, brk, rret, test, m_brk, m_rret);
    end else if (ring !== m_ring) begin
      fails++;
      $display("FAIL R6 cycle %0d: ring=%b expected %b", cyc, ring, m_ring);
    end else if (tflag_n !== !therm_int) begin
      fails++;
      $display("FAIL R11 cycle %0d: flag=%b expected %b", cyc, tflag_n, !therm_int);
    end
  end

  task automatic go(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {brk,rret,ring,test}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] sw();
    return {brk, rret, ring, test};
  endfunction

  initial begin
    #2;
    go(3);
    chk("R1", sw(), 4'b0000);
    tests++;
    if (tflag_n !== 1'b1) begin fails++; $display("FAIL R1: flag=%b expected 1", tflag_n); end
    rst_n = 1'b1;
    pg = 1'b1; mode = 3'b000; hold = 1'b1;
    go(4);
    chk("R9 unarmed", sw(), 4'b0000);
    hold = 1'b0;
    go(2);
    chk("R2 talk", sw(), 4'b1000);
    mode = 3'b010;
    go(1);
    chk("R2 not yet", sw(), 4'b1000);
    go(1);
    chk("R4 ringing", sw(), 4'b0110);
    // make-before-break
    mode = 3'b000;
    go(2);
    chk("R7 transient", sw(), 4'b1010);
    go(5);
    chk("R6 ring held", sw(), 4'b1010);
    zc = 1'b1;
    go(2);
    chk("R6 before zc edge", sw(), 4'b1010);
    go(1);
    chk("R7 after zc", sw(), 4'b1000);
    zc = 1'b0;
    // zero crossing while ringing commanded
    mode = 3'b010;
    go(3);
    zc = 1'b1; go(4); zc = 1'b0; go(1);
    chk("R6 zc ignored", sw(), 4'b0110);
    // hold freezes ringing
    hold = 1'b1; mode = 3'b000;
    go(4);
    chk("R3 frozen", sw(), 4'b0110);
    mode = 3'b011;
    go(3);
    chk("R3 frozen2", sw(), 4'b0110);
    // break-before-make with hold still set
    kill_n = 1'b0;
    go(1);
    chk("R8 kill", sw(), 4'b0010);
    hold = 1'b0; mode = 3'b000;
    go(4);
    chk("R5 kill over latch", sw(), 4'b0010);
    zc = 1'b1; go(3); zc = 1'b0;
    chk("R8 ring opened", sw(), 4'b0000);
    kill_n = 1'b1;
    go(1);
    chk("R8 break closes", sw(), 4'b1000);
    // undefined codes
    for (int m = 1; m < 8; m++) begin
      if (m == 2) continue;
      mode = 3'(m);
      go(3);
      chk("R4 undefined", sw(), 4'b0000);
    end
    mode = 3'b000;
    go(2);
    therm_n = 1'b0;
    go(1);
    chk("R5 therm_n", sw(), 4'b0000);
    therm_n = 1'b1;
    go(1);
    chk("R11 therm_n high", sw(), 4'b1000);
    therm_int = 1'b1;
    go(1);
    chk("R11 internal", sw(), 4'b0000);
    tests++;
    if (tflag_n !== 1'b0) begin fails++; $display("FAIL R11: flag=%b expected 0", tflag_n); end
    therm_int = 1'b0;
    go(1);
    // battery hysteresis
    bat_fail = 1'b1;
    go(1);
    bat_fail = 1'b0;
    go(1);
    chk("R10 blocked", sw(), 4'b0000);
    go(4);
    chk("R10 held", sw(), 4'b0000);
    bat_ok = 1'b1;
    go(2);
    chk("R10 released", sw(), 4'b1000);
    bat_ok = 1'b0;
    // supply loss and re-arm
    pg = 1'b0; hold = 1'b1;
    go(1);
    chk("R9 supply low", sw(), 4'b0000);
    pg = 1'b1;
    go(5);
    chk("R9 wait arm", sw(), 4'b0000);
    hold = 1'b0;
    go(1);
    chk("R9 arm edge", sw(), 4'b0000);
    go(1);
    chk("R9 armed", sw(), 4'b1000);
    go(3);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not end, expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule